// File: doc/BRIEF.md
# Segment Lookaside Buffer

This block keeps a parameterized set of segment descriptors and turns a 64-bit effective address into a 50-bit virtual segment identifier. Alongside the identifier it returns the byte-offset mask of the segment and an 8-bit attribute byte. Each descriptor has two words. The first word is 64 bits wide and holds the segment tag, the valid flag, the size code and the high identifier bits. The second word is 32 bits wide and holds the low identifier bits and the attributes. Only 256 MB segments are translated.

A lookup request is compared against every descriptor in the same cycle, and the result is registered. If several descriptors match, the one with the lowest index wins. If none matches, the result carries a segment-fault flag.

The block also has a compact segment-register port for older software. A 4-bit segment number picks a descriptor. A 32-bit register value is spread into the two-word format on a write and folded back out on a read. A write through this port also sets the valid flag and puts the segment number into the tag. A raw descriptor load port lets the surrounding logic place any two-word descriptor at any index.

Top module: `seg_lookaside`

## Requirements
- R1: After reset every descriptor is invalid and `resValid` and `regRdValid` are low. A lookup then reports a fault, and a register read returns 0.
- R2: A raw load (`entryWrEn`) stores `entryW1` and `entryW2` at index `entryIdx`. The new contents are used from the next clock onward.
- R3: A descriptor matches an address only when all of these hold: first-word bit 27 (valid) is 1, first-word bits 26:25 (size code) are 00, and address bits 63:28 equal first-word bits 63:28. A non-zero size code never matches.
- R4: A lookup requested in cycle N is answered in cycle N+1 with `resValid` high. On a hit, `resVsid` = {w1[25:0], w2[31:8]}, `resAttr` = w2[7:0] and `resPageMask` = 64'h0000_0000_0FFF_FFFF. With no request, `resValid` stays low.
- R5: When several descriptors match, the result comes from the lowest index.
- R6: On a miss, `resFault` is 1 and `resHit` is 0, and `resVsid`, `resAttr` and `resPageMask` are all zero. On a hit, `resHit` is 1 and `resFault` is 0.
- R7: A register write with segment number s and value rs stores the following at index s: w1 = (s << 28) | (1 << 27) | rs[26:24], and w2 = {rs[23:0], rs[30:27], 4'b0000}. A lookup of address s << 28 then hits.
- R8: A register read of segment s answers one cycle later on `regRdData`, with `regRdValid` high. The value is 0 when w1 bit 27 is clear. Otherwise it is {1'b0, w2[7:4], w1[2:0], w2[31:8]}, so a write followed by a read returns rs & 32'h7FFF_FFFF.
- R9: When a register write and a raw load happen in the same cycle, only the register write takes effect, and the raw load is dropped.
- R10: A lookup or register read in the same cycle as a write sees the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request |
| lookupEa | input | 64 | Effective address to translate |
| entryWrEn | input | 1 | Raw descriptor load strobe |
| entryIdx | input | $clog2(NUM_ENTRIES) | Raw load index |
| entryW1 | input | 64 | Raw first word |
| entryW2 | input | 32 | Raw second word |
| regWrEn | input | 1 | Segment-register write strobe |
| regRdEn | input | 1 | Segment-register read strobe |
| regSegNum | input | 4 | Segment number for register access |
| regWrData | input | 32 | Segment-register value to write |
| resValid | output | 1 | Lookup result present |
| resHit | output | 1 | A descriptor matched |
| resFault | output | 1 | No descriptor matched |
| resVsid | output | 50 | Virtual segment identifier |
| resPageMask | output | 64 | Offset mask of the segment |
| resAttr | output | 8 | Attribute byte |
| regRdValid | output | 1 | Register read data present |
| regRdData | output | 32 | Folded segment-register value |

## Verification
The bench builds the block with 20 descriptors. This count is not a power of two, so the index field has spare codes. It also places four descriptors beyond the sixteen that the register port can reach. Those upper slots are filled only by raw loads, which makes it possible to test priority between raw-loaded and register-written descriptors. It also shows that a lookup scans the whole array and not just the register-port range.

// File: rtl/seg_lookaside_pkg.sv
package seg_lookaside_pkg;
  localparam int EA_W      = 64;
  localparam int VSID_W    = 50;
  localparam int SEG_LSB   = 28;
  localparam int VALID_BIT = 27;
  localparam int SIZE_MSB  = 26;
  localparam int SIZE_LSB  = 25;
  localparam logic [EA_W-1:0] OFFSET_MASK = (64'd1 << SEG_LSB) - 64'd1;

  typedef struct packed {
    logic wrEn;
    logic lkEn;
    logic rdEn;
  } slbStrobes_t;
endpackage

// File: rtl/seg_lookaside_ctrl.sv
module seg_lookaside_ctrl
  import seg_lookaside_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              lookupValid,
  input  logic              entryWrEn,
  input  logic [IDX_W-1:0]  entryIdx,
  input  logic [63:0]       entryW1,
  input  logic [31:0]       entryW2,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [3:0]        regSegNum,
  input  logic [31:0]       regWrData,
  output slbStrobes_t       strobes,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [63:0]       wrW1,
  output logic [31:0]       wrW2,
  output logic [IDX_W-1:0]  rdIdx
);
  logic unusedRsTop;
  assign unusedRsTop = regWrData[31];

  // Register-port writes take priority over raw loads (R9)
  always_comb begin
    strobes.lkEn = lookupValid;
    strobes.rdEn = regRdEn;
    strobes.wrEn = regWrEn | entryWrEn;
    rdIdx        = IDX_W'(regSegNum);
    if (regWrEn) begin
      wrIdx = IDX_W'(regSegNum);
      // R7: spread register bits into the two-word descriptor
      wrW1  = ({60'd0, regSegNum} << SEG_LSB) | (64'd1 << VALID_BIT) |
              {61'd0, regWrData[26:24]};
      wrW2  = {regWrData[23:0], regWrData[30:27], 4'b0000};
    end else begin
      wrIdx = entryIdx;
      wrW1  = entryW1;
      wrW2  = entryW2;
    end
  end
endmodule

// File: rtl/seg_lookaside_dp.sv
module seg_lookaside_dp
  import seg_lookaside_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int IDX_W       = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  slbStrobes_t       strobes,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [63:0]       wrW1,
  input  logic [31:0]       wrW2,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [EA_W-1:0]   lookupEa,
  output logic              resValid,
  output logic              resHit,
  output logic              resFault,
  output logic [VSID_W-1:0] resVsid,
  output logic [EA_W-1:0]   resPageMask,
  output logic [7:0]        resAttr,
  output logic              regRdValid,
  output logic [31:0]       regRdData
);
  logic [63:0]            w1Q [NUM_ENTRIES];
  logic [31:0]            w2Q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]       selIdx;
  logic                   anyMatch;
  logic                   unusedEaLow;

  assign unusedEaLow = ^lookupEa[SEG_LSB-1:0];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    logic wrHere;
    assign wrHere = strobes.wrEn && (wrIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        w1Q[i] <= '0;
        w2Q[i] <= '0;
      end else if (wrHere) begin
        w1Q[i] <= wrW1;
        w2Q[i] <= wrW2;
      end
    end

    // R3: valid, size code 00, tag equal on bits 63:28
    assign matchVec[i] = w1Q[i][VALID_BIT] &&
                         (w1Q[i][SIZE_MSB:SIZE_LSB] == 2'b00) &&
                         (lookupEa[EA_W-1:SEG_LSB] == w1Q[i][63:SEG_LSB]);

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
      wrHere |=> (w1Q[i] == $past(wrW1)) && (w2Q[i] == $past(wrW2)));
  end

  // R5: lowest matching index wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) selIdx = IDX_W'(i);
    end
  end
  assign anyMatch = |matchVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid    <= 1'b0;
      resHit      <= 1'b0;
      resFault    <= 1'b0;
      resVsid     <= '0;
      resPageMask <= '0;
      resAttr     <= '0;
    end else begin
      resValid <= strobes.lkEn;
      if (strobes.lkEn) begin
        resHit   <= anyMatch;
        resFault <= !anyMatch;
        if (anyMatch) begin
          resVsid     <= {w1Q[selIdx][25:0], w2Q[selIdx][31:8]};
          resPageMask <= OFFSET_MASK;
          resAttr     <= w2Q[selIdx][7:0];
        end else begin
          resVsid     <= '0;
          resPageMask <= '0;
          resAttr     <= '0;
        end
      end
    end
  end

  // R8: fold a descriptor back into register form
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdValid <= 1'b0;
      regRdData  <= '0;
    end else begin
      regRdValid <= strobes.rdEn;
      if (strobes.rdEn) begin
        if (w1Q[rdIdx][VALID_BIT])
          regRdData <= {1'b0, w2Q[rdIdx][7:4], w1Q[rdIdx][2:0], w2Q[rdIdx][31:8]};
        else
          regRdData <= '0;
      end
    end
  end

  p_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lkEn |=> resValid);
  p_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.lkEn |=> !resValid);
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resHit != resFault));
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resFault) |-> (resVsid == '0 && resAttr == '0 && resPageMask == '0));
  p_rd_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdEn |=> regRdValid);
  p_rd_msb_r8: assert property (@(posedge clk) disable iff (!rstN)
    regRdValid |-> !regRdData[31]);
endmodule

// File: rtl/seg_lookaside.sv
module seg_lookaside
  import seg_lookaside_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [63:0]       lookupEa,
  input  logic              entryWrEn,
  input  logic [IDX_W-1:0]  entryIdx,
  input  logic [63:0]       entryW1,
  input  logic [31:0]       entryW2,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [3:0]        regSegNum,
  input  logic [31:0]       regWrData,
  output logic              resValid,
  output logic              resHit,
  output logic              resFault,
  output logic [49:0]       resVsid,
  output logic [63:0]       resPageMask,
  output logic [7:0]        resAttr,
  output logic              regRdValid,
  output logic [31:0]       regRdData
);
  slbStrobes_t      strobes;
  logic [IDX_W-1:0] wrIdx;
  logic [63:0]      wrW1;
  logic [31:0]      wrW2;
  logic [IDX_W-1:0] rdIdx;

  seg_lookaside_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .lookupValid(lookupValid), .entryWrEn(entryWrEn), .entryIdx(entryIdx),
    .entryW1(entryW1), .entryW2(entryW2), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regSegNum(regSegNum), .regWrData(regWrData), .strobes(strobes),
    .wrIdx(wrIdx), .wrW1(wrW1), .wrW2(wrW2), .rdIdx(rdIdx)
  );

  seg_lookaside_dp #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrIdx(wrIdx), .wrW1(wrW1),
    .wrW2(wrW2), .rdIdx(rdIdx), .lookupEa(lookupEa), .resValid(resValid),
    .resHit(resHit), .resFault(resFault), .resVsid(resVsid),
    .resPageMask(resPageMask), .resAttr(resAttr), .regRdValid(regRdValid),
    .regRdData(regRdData)
  );
endmodule

// File: tb/test_seg_lookaside.sv
module test_seg_lookaside;
  localparam int N  = 20;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [63:0] lookupEa = '0;
  logic entryWrEn = 1'b0;
  logic [IW-1:0] entryIdx = '0;
  logic [63:0] entryW1 = '0;
  logic [31:0] entryW2 = '0;
  logic regWrEn = 1'b0;
  logic regRdEn = 1'b0;
  logic [3:0] regSegNum = '0;
  logic [31:0] regWrData = '0;
  logic resValid, resHit, resFault, regRdValid;
  logic [49:0] resVsid;
  logic [63:0] resPageMask;
  logic [7:0] resAttr;
  logic [31:0] regRdData;

  always #2 clk = ~clk;

  seg_lookaside #(.NUM_ENTRIES(N)) i_seg_lookaside (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupEa(lookupEa),
    .entryWrEn(entryWrEn), .entryIdx(entryIdx), .entryW1(entryW1), .entryW2(entryW2),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regSegNum(regSegNum), .regWrData(regWrData),
    .resValid(resValid), .resHit(resHit), .resFault(resFault), .resVsid(resVsid),
    .resPageMask(resPageMask), .resAttr(resAttr), .regRdValid(regRdValid),
    .regRdData(regRdData)
  );

  int nChecks = 0;
  int nFail = 0;

  typedef struct { logic [127:0] val; string tag; } lkItem_t;
  typedef struct { logic [31:0] val; string tag; } rdItem_t;
  lkItem_t lkQ[$];
  rdItem_t rdQ[$];

  logic [63:0] m1 [N];
  logic [31:0] m2 [N];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Expected lookup result {hit, fault, vsid, attr, mask}, padded to 128 bits
  function automatic logic [127:0] modelLookup(input logic [63:0] ea);
    for (int i = 0; i < N; i++) begin
      if (m1[i][27] && m1[i][26:25] == 2'b00 && ea[63:28] == m1[i][63:28])
        return {4'd0, 1'b1, 1'b0, m1[i][25:0], m2[i][31:8], m2[i][7:0],
                64'h0000_0000_0FFF_FFFF};
    end
    return {4'd0, 1'b0, 1'b1, 50'd0, 8'd0, 64'd0};
  endfunction

  function automatic logic [31:0] modelRead(input logic [3:0] s);
    if (!m1[s][27]) return 32'd0;
    return {1'b0, m2[s][7:4], m1[s][2:0], m2[s][31:8]};
  endfunction

  // Driver: one cycle of stimulus, expected items pushed before the write lands
  task automatic drive(input logic lk, input logic [63:0] ea,
                       input logic ld, input logic [IW-1:0] li,
                       input logic [63:0] l1, input logic [31:0] l2,
                       input logic rw, input logic rd, input logic [3:0] seg,
                       input logic [31:0] rs, input string tag);
    lkItem_t a;
    rdItem_t b;
    if (lk) begin a.val = modelLookup(ea); a.tag = tag; lkQ.push_back(a); end
    if (rd) begin b.val = modelRead(seg); b.tag = tag; rdQ.push_back(b); end
    lookupValid = lk; lookupEa = ea;
    entryWrEn = ld; entryIdx = li; entryW1 = l1; entryW2 = l2;
    regWrEn = rw; regRdEn = rd; regSegNum = seg; regWrData = rs;
    @(negedge clk);
    lookupValid = 0; entryWrEn = 0; regWrEn = 0; regRdEn = 0;
    if (rw) begin
      m1[seg] = (64'(seg) << 28) | (64'd1 << 27) | 64'(rs[26:24]);
      m2[seg] = {rs[23:0], rs[30:27], 4'b0000};
    end else if (ld && int'(li) < N) begin
      m1[li] = l1;
      m2[li] = l2;
    end
  endtask

  task automatic lookup(input logic [63:0] ea, input string tag);
    drive(1, ea, 0, '0, '0, '0, 0, 0, '0, '0, tag);
  endtask
  task automatic load(input logic [IW-1:0] i, input logic [63:0] w1, input logic [31:0] w2);
    drive(0, '0, 1, i, w1, w2, 0, 0, '0, '0, "R2");
  endtask
  task automatic regWr(input logic [3:0] s, input logic [31:0] rs);
    drive(0, '0, 0, '0, '0, '0, 1, 0, s, rs, "R7");
  endtask
  task automatic regRd(input logic [3:0] s, input string tag);
    drive(0, '0, 0, '0, '0, '0, 0, 1, s, '0, tag);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (resValid) begin
        if (lkQ.size() == 0) chk(0, "R4 unexpected result", 128'(resValid), 0);
        else begin
          lkItem_t e;
          logic [127:0] act;
          e = lkQ.pop_front();
          act = {4'd0, resHit, resFault, resVsid, resAttr, resPageMask};
          chk(act == e.val, e.tag, act, e.val);
        end
      end
      if (regRdValid) begin
        if (rdQ.size() == 0) chk(0, "R8 unexpected read", 128'(regRdValid), 0);
        else begin
          rdItem_t e;
          e = rdQ.pop_front();
          chk(regRdData == e.val, e.tag, 128'(regRdData), 128'(e.val));
        end
      end
    end
  end

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    for (int i = 0; i < N; i++) begin m1[i] = '0; m2[i] = '0; end
    repeat (3) @(negedge clk);
    chk(resValid == 0 && regRdValid == 0, "R1 reset outputs",
        128'({resValid, regRdValid}), 0);
    rstN = 1;
    @(negedge clk);
    // R1: empty array faults, read returns 0
    lookup(64'h0, "R1");
    regRd(4'd3, "R1");
    // R2/R4: raw load then hit at index 17
    load(5'd17, 64'h1234_5678_9000_0000 | 64'h0800_0000 | 64'h00AB_CDE1, 32'hDEAD_BE5A);
    lookup(64'h1234_5678_9ABC_DEF0, "R4");
    lookup(64'h1234_5678_8FFF_FFFF, "R6");
    // R3: non-zero size code and clear valid never match
    load(5'd18, 64'h5555_0000_1000_0000 | 64'h0800_0000 | 64'h0200_0000, 32'h1111_1111);
    lookup(64'h5555_0000_1000_0004, "R3");
    load(5'd19, 64'h7777_0000_2000_0000, 32'h2222_2222);
    lookup(64'h7777_0000_2000_0000, "R3");
    // R5: lowest index wins
    load(5'd5, 64'hAAAA_0000_2000_0000 | 64'h0800_0000 | 64'h0000_0055, 32'h5500_00A5);
    load(5'd2, 64'hAAAA_0000_2000_0000 | 64'h0800_0000 | 64'h0000_0022, 32'h2200_00B2);
    lookup(64'hAAAA_0000_2345_6789, "R5");
    load(5'd2, 64'hAAAA_0000_2000_0000, 32'h0);
    lookup(64'hAAAA_0000_2000_0000, "R5");
    regRd(4'd2, "R8");
    regRd(4'd5, "R8");
    // R7/R8: register write, lookup, round-trip read
    regWr(4'd7, 32'hFABC_DEF1);
    lookup(64'h0000_0000_7012_3456, "R7");
    lookup(64'h0000_0001_7000_0000, "R3");
    regRd(4'd7, "R8");
    chk(modelRead(4'd7) == 32'h7ABC_DEF1, "R8 round trip", 128'(modelRead(4'd7)),
        128'h7ABC_DEF1);
    // R9: both write kinds together, raw load dropped
    drive(0, '0, 1, 5'd12, 64'hBBBB_0000_3000_0000 | 64'h0800_0000, 32'h3333_3333,
          1, 0, 4'd9, 32'h0123_4567, "R9");
    lookup(64'hBBBB_0000_3000_0000, "R9");
    lookup(64'h0000_0000_9000_0000, "R9");
    // R10: lookup and read in the write cycle see old contents
    drive(1, 64'h0000_0000_4000_0000, 0, '0, '0, '0, 1, 1, 4'd4, 32'h3C00_1234, "R10");
    lookup(64'h0000_0000_4ABC_0000, "R10");
    regRd(4'd4, "R10");
    // Back-to-back lookups
    lookup(64'h1234_5678_9000_0000, "R4");
    lookup(64'hAAAA_0000_2FFF_FFFF, "R5");
    lookup(64'h0000_0000_7FFF_FFFF, "R7");
    repeat (3) @(negedge clk);
    chk(lkQ.size() == 0 && rdQ.size() == 0, "R4 all results delivered",
        128'(lkQ.size() + rdQ.size()), 0);
    finishRun();
  end
endmodule